// File: doc/BRIEF.md
# Streaming Dot-Product Engine with Rotating Partial Sums

This block forms the signed inner product of two integer vectors whose elements arrive as pairs, at most one pair per clock. A start pulse supplies the vector length. Each accepted pair goes into a four-stage multiplier. Products then leave the multiplier and enter a four-stage adder whose last stage loops back to its first. As a result, four independent running sums rotate through the adder. No single accumulator has to wait for an addition to finish, so the unit takes a new pair on every clock.

After the final pair, the engine waits until the multiplier has emptied and then adds the four running sums together. It then presents the total with a one-cycle done pulse. A clock with no valid pair simply adds zero to the slot passing the loop point. Gaps in the stream and lengths that are not a multiple of four therefore need no special handling. Elements are 16-bit signed, products are 32-bit and the sums are 40-bit, which holds any vector of up to 256 elements without overflow.

Top module: `dotp_unit`

## Requirements
- R1: While reset is high and after it is released, done is 0 and result is 0.
- R2: After a start pulse with length L (1 to 256), the engine accepts exactly L pairs: the pairs presented with in_valid high. Clocks with in_valid low are skipped and do not count.
- R3: result equals the sum over all accepted pairs of a*b, all signed, as a 40-bit two's-complement value. It is presented together with done, which is high for exactly one clock per run.
- R4: Lengths that are not a multiple of four (1, 2, 3, 5, 7, 13) give the exact dot product.
- R5: A start pulse that arrives while a run is in progress (from the accepting start until done) is ignored. The run keeps its original length and result.
- R6: in_valid is ignored while idle and after the L-th pair of a run has been accepted. Such pairs do not change result and do not produce done.
- R7: A start with length 0 produces done with result 0.
- R8: With one pair on every clock, done is asserted no more than L+8 clocks after the clock edge that samples start.
- R9: The extreme operands (every element -32768 times -32768, or -32768 times 32767, over 256 elements) produce the exact result without overflow.
- R10: result changes only on a clock in which done is high, and holds its value between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; sampled only while idle |
| vec_len | input | 9 | Number of pairs in the run, 0 to 256 |
| in_valid | input | 1 | Current a/b pair is valid |
| a_in | input | 16 | Element of vector A, signed |
| b_in | input | 16 | Element of vector B, signed |
| result | output | 40 | Inner product, signed, held until the next run ends |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
The checker assumes that start is held low during reset and that vec_len never exceeds 256. Under these conditions the pair counter cannot pass the latched length. Its rules that the length holds for a whole run and that the busy state rises only after a start also rely on those assumptions. The stimulus keeps every length in 0 to 256 and raises start only outside reset. It also places extra start pulses and stray valid pairs deliberately inside and after runs, so that the ignore rules are tested rather than merely avoided.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

    localparam int DATA_W     = 16;
    localparam int PROD_W     = 2 * DATA_W;
    localparam int ACC_W      = 40;
    localparam int LEN_W      = 9;
    localparam int MUL_STAGES = 4;
    localparam int ADD_STAGES = 4;

    typedef logic signed [DATA_W-1:0] elem_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [LEN_W-1:0]         len_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FEED   = 2'd1,
        PH_DRAIN  = 2'd2,
        PH_REDUCE = 2'd3
    } phase_t;

    typedef struct packed {
        logic  vld;
        prod_t val;
    } prod_slot_t;

    function automatic acc_t widen(input prod_t p);
        return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/dotp_mul_pipe.sv
module dotp_mul_pipe
    import dotp_pkg::*;
#(
    parameter int STAGES = MUL_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  elem_t      a,
    input  elem_t      b,
    output prod_slot_t out_slot,
    output logic       busy
);
    localparam int PSTG = STAGES - 1;

    elem_t      a_q, b_q;
    logic       v_q;
    prod_slot_t slot_q [PSTG];
    prod_t      mul_res;
    logic [PSTG-1:0] slot_v;

    always_comb mul_res = prod_t'(a_q) * prod_t'(b_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            a_q <= '0;
            b_q <= '0;
            slot_q[0] <= '0;
        end else begin
            v_q <= in_vld;
            a_q <= a;
            b_q <= b;
            slot_q[0] <= '{vld: v_q, val: mul_res};
        end
    end

    for (genvar i = 1; i < PSTG; i++) begin : g_delay
        always_ff @(posedge clk) begin
            if (rst) slot_q[i] <= '0;
            else     slot_q[i] <= slot_q[i-1];
        end
    end

    for (genvar i = 0; i < PSTG; i++) begin : g_vbits
        assign slot_v[i] = slot_q[i].vld;
    end

    assign out_slot = slot_q[PSTG-1];
    assign busy     = v_q | (|slot_v);
endmodule

// File: rtl/dotp_acc_ring.sv
module dotp_acc_ring
    import dotp_pkg::*;
#(
    parameter int SLOTS = ADD_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  prod_slot_t add_in,
    output acc_t       total
);
    acc_t ring_q [SLOTS];
    acc_t addend;

    always_comb addend = add_in.vld ? widen(add_in.val) : '0;

    always_ff @(posedge clk) begin
        if (rst || clear) ring_q[0] <= '0;
        else              ring_q[0] <= ring_q[SLOTS-1] + addend;
    end

    for (genvar i = 1; i < SLOTS; i++) begin : g_ring
        always_ff @(posedge clk) begin
            if (rst || clear) ring_q[i] <= '0;
            else              ring_q[i] <= ring_q[i-1];
        end
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < SLOTS; i++) total = total + ring_q[i];
    end
endmodule

// File: rtl/dotp_ctrl.sv
module dotp_ctrl
    import dotp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  len_t   vec_len,
    input  logic   in_valid,
    input  logic   pipe_busy,
    output logic   accept,
    output logic   clear,
    output logic   reduce_go,
    output logic   busy,
    output len_t   cnt_o,
    output len_t   len_o
);
    phase_t phase_q;
    len_t   cnt_q, len_q, cnt_nx;

    assign accept    = (phase_q == PH_FEED) && in_valid;
    assign clear     = (phase_q == PH_IDLE) && start;
    assign reduce_go = (phase_q == PH_REDUCE);
    assign busy      = (phase_q != PH_IDLE);
    assign cnt_nx    = cnt_q + 1'b1;
    assign cnt_o     = cnt_q;
    assign len_o     = len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    len_q   <= vec_len;
                    cnt_q   <= '0;
                    phase_q <= (vec_len == '0) ? PH_DRAIN : PH_FEED;
                end
                PH_FEED: if (in_valid) begin
                    cnt_q <= cnt_nx;
                    if (cnt_nx == len_q) phase_q <= PH_DRAIN;
                end
                PH_DRAIN: if (!pipe_busy) phase_q <= PH_REDUCE;
                PH_REDUCE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dotp_unit.sv
module dotp_unit
    import dotp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [ACC_W-1:0]  result,
    output logic              done
);
    logic       accept, clear, reduce_go, busy, pipe_busy;
    len_t       ctl_cnt, ctl_len;
    prod_slot_t mul_out;
    acc_t       ring_total;
    acc_t       result_q;
    logic       done_q;

    dotp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .vec_len(vec_len),
        .in_valid(in_valid), .pipe_busy(pipe_busy), .accept(accept),
        .clear(clear), .reduce_go(reduce_go), .busy(busy),
        .cnt_o(ctl_cnt), .len_o(ctl_len)
    );

    dotp_mul_pipe #(.STAGES(MUL_STAGES)) u_mul (
        .clk(clk), .rst(rst), .in_vld(accept), .a(elem_t'(a_in)),
        .b(elem_t'(b_in)), .out_slot(mul_out), .busy(pipe_busy)
    );

    dotp_acc_ring #(.SLOTS(ADD_STAGES)) u_ring (
        .clk(clk), .rst(rst), .clear(clear), .add_in(mul_out),
        .total(ring_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= reduce_go;
            if (reduce_go) result_q <= ring_total;
        end
    end

    assign result = result_q;
    assign done   = done_q;
endmodule

// File: rtl/dotp_unit_chk.sv
module dotp_unit_chk
    import dotp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [ACC_W-1:0] result,
    input logic             busy,
    input len_t             cnt,
    input len_t             len_q
);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_len_held_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(len_q)));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= len_q));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);
endmodule

bind dotp_unit dotp_unit_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .result(result),
    .busy(busy), .cnt(ctl_cnt), .len_q(ctl_len)
);

// File: tb/dotp_unit_test.sv
`timescale 1ns/1ps
module dotp_unit_test;
    localparam int NV = 12;
    localparam int TAB_LEN  [NV] = '{1, 2, 3, 4, 5, 7, 8, 13, 64, 256, 256, 0};
    localparam int TAB_MODE [NV] = '{0, 1, 4, 0, 4, 1, 4, 4, 4, 2, 3, 0};
    localparam int TAB_GAP  [NV] = '{0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [8:0]        vec_len = '0;
    logic              in_valid = 1'b0;
    logic [15:0]       a_in = '0, b_in = '0;
    logic signed [39:0] result;
    logic              done;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dotp_unit uut (
        .clk(clk), .rst(rst), .start(start), .vec_len(vec_len),
        .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
        .result(result), .done(done)
    );

    function automatic logic signed [15:0] gen_a(int mode, int k);
        case (mode)
            0: return 16'(k + 1);
            1: return (k % 2) ? 16'(-(k * 37)) : 16'(k * 53);
            2: return 16'sh8000;
            3: return 16'sh8000;
            default: return 16'(k * 7919 + 13);
        endcase
    endfunction

    function automatic logic signed [15:0] gen_b(int mode, int k);
        case (mode)
            0: return 16'(k + 2);
            1: return 16'(k * 11 - 40);
            2: return 16'sh8000;
            3: return 16'sh7fff;
            default: return 16'((k * 104729) ^ 32'h5a5a);
        endcase
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one vector; returns cycles from sampled start to done, -1 on timeout.
    task automatic run_vec(int len, int mode, int gap, bit ign, int extra,
                           output longint res, output int lat);
        int cyc;
        @(negedge clk);
        start = 1'b1; vec_len = 9'(len);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        lat = -1;
        for (int k = 0; k < len; k++) begin
            if (gap != 0 && (k % 3) == 1) begin
                in_valid = 1'b0; a_in = 16'h7777; b_in = 16'h7777;
                @(negedge clk); cyc++;
            end
            in_valid = 1'b1; a_in = gen_a(mode, k); b_in = gen_b(mode, k);
            if (ign && k == 4) begin start = 1'b1; vec_len = 9'd2; end
            else start = 1'b0;
            @(negedge clk); cyc++;
            if (done && lat < 0) lat = cyc;
        end
        start = 1'b0;
        for (int e = 0; e < extra; e++) begin
            in_valid = 1'b1; a_in = 16'h1234; b_in = 16'h0101;
            if (done && lat < 0) lat = cyc;
            @(negedge clk); cyc++;
        end
        in_valid = 1'b0;
        while (!done && lat < 0 && cyc < 2000) begin
            @(negedge clk); cyc++;
        end
        if (lat < 0 && done) lat = cyc;
        res = longint'(result);
    endtask

    function automatic longint expect_sum(int len, int mode);
        longint s = 0;
        for (int k = 0; k < len; k++)
            s += longint'(gen_a(mode, k)) * longint'(gen_b(mode, k));
        return s;
    endfunction

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint res, exp, prev;
        int lat;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(result == 0, "R1 result in reset", result, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && result == 0, "R1 after reset", result, 0);

        // R6: valid pairs while idle do nothing
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; a_in = 16'd500; b_in = 16'd600;
            @(negedge clk);
            check(done == 1'b0, "R6 idle done", done, 0);
        end
        in_valid = 1'b0;
        check(result == 0, "R6 idle result", result, 0);

        // Table walk: R2, R3, R4, R7, R8, R9
        for (int t = 0; t < NV; t++) begin
            run_vec(TAB_LEN[t], TAB_MODE[t], TAB_GAP[t], 1'b0, 0, res, lat);
            exp = expect_sum(TAB_LEN[t], TAB_MODE[t]);
            check(lat >= 0, "R3 done seen", lat, 1);
            check(res == exp, (TAB_LEN[t] == 0) ? "R7 zero length" :
                  (TAB_MODE[t] >= 2 && TAB_MODE[t] <= 3) ? "R9 extreme" :
                  (TAB_LEN[t] % 4 != 0) ? "R4 odd length" : "R2 R3 sum", res, exp);
            @(negedge clk);
            check(done == 1'b0, "R3 single pulse", done, 0);
            if (TAB_GAP[t] == 0 && TAB_LEN[t] > 0)
                check(lat <= TAB_LEN[t] + 8, "R8 latency", lat, TAB_LEN[t] + 8);
        end

        // R10: result holds between runs
        prev = longint'(result);
        repeat (5) @(negedge clk);
        check(longint'(result) == prev, "R10 hold", result, prev);

        // R5: start during run is ignored
        run_vec(9, 4, 0, 1'b1, 0, res, lat);
        exp = expect_sum(9, 4);
        check(res == exp, "R5 restart ignored", res, exp);
        repeat (12) @(negedge clk);
        check(done == 1'b0, "R5 no second done", done, 0);
        check(longint'(result) == exp, "R5 result kept", result, exp);

        // R6: surplus pairs after the L-th are ignored
        run_vec(6, 1, 0, 1'b0, 5, res, lat);
        exp = expect_sum(6, 1);
        check(res == exp, "R6 surplus pairs", res, exp);

        // R2: gapped stream with different length
        run_vec(11, 0, 1, 1'b0, 0, res, lat);
        exp = expect_sum(11, 0);
        check(res == exp, "R2 gapped stream", res, exp);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule